// File: doc/BRIEF.md
# Power-IC Voltage Command Frame Generator

This block builds the three-byte write command that moves a power-management IC to a new supply level. Each frame is a slave address, a register address and one voltage-select byte. There are two ways to start a frame. A power-state request picks one of four voltage codes held in a packed command word. A software bypass register supplies all three fields directly. The frame goes out as parallel fields with a one-cycle start strobe to an external serial bus master. That master later reports completion, together with an acknowledge or not-acknowledge flag.

A five-bit channel configuration word decides, field by field, whether the channel's own slave address, voltage register address, command register address and command word are used, or the shared default values are used instead. The placement of these bits within the word is chosen by a parameter, because one channel variant orders them differently. A second parameter marks the default channel. On that channel only the command-register-enable bit can be written.

At most one frame is in flight at a time. State requests that arrive while a frame is busy wait in a single slot, and a newer request replaces an older one. A pending bypass command is served before a waiting state request. The bypass valid bit stays set until the bus master reports completion and then clears itself. A not-acknowledge sets an error flag that stays set, and the rejected frame is not sent again.

Top module: `vcf_frame_gen`

## Requirements
- R1: After reset, frame_start_o, busy_o and err_o are 0, the configuration readback and the own command word read 0, and the bypass valid bit is 0.
- R2: The command word packs four 8-bit codes. Requested state 0 (ON) selects bits 31:24, 1 (low-power ON) selects 23:16, 2 (RETENTION) selects 15:8 and 3 (OFF) selects 7:0. A state frame carries the code of the requested state, taken from the own word when the code-enable bit is set and from dflt_cmd_i otherwise.
- R3: With MUTANT_MAP=0 the configuration bits are: slave address bit 0, voltage register address bit 1, command register address bit 2, command-register-enable bit 3, command code bit 4. A set bit selects the own value and a clear bit selects the shared default.
- R4: With MUTANT_MAP=1 the order is: slave address bit 0, command code bit 1, voltage register address bit 2, command register address bit 3, command-register-enable bit 4.
- R5: With DEFAULT_CH=1, a configuration write keeps only the command-register-enable bit, and every other bit reads 0.
- R6: A state frame uses the effective command register address when command-register-enable is in effect, and the effective voltage register address otherwise. Command-register-enable is in effect, and reads back as 1, when its stored bit is set or when the two effective addresses are equal.
- R7: The bypass word holds data in bits 7:0, register address in 15:8, slave address in 22:16 and valid in bit 24. A write with valid set launches a frame with those fields. Writes made while valid is set are ignored.
- R8: The bypass valid bit stays set while its frame is in flight and clears in the cycle after bus_done_i.
- R9: frame_start_o is a one-cycle pulse and busy_o rises with it. The frame fields stay stable while busy. busy_o falls in the cycle after bus_done_i.
- R10: When a bypass command and a state request are both pending with no frame in flight, the bypass frame goes first and the state frame follows it.
- R11: State requests made while busy are held one deep. After completion, exactly one frame follows, carrying the latest requested state.
- R12: bus_nack_i together with bus_done_i sets err_o, which then stays set. The rejected frame is not retried.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration word write strobe |
| cfg_wdata_i | input | 5 | Configuration write data |
| cfg_rd_o | output | 5 | Configuration readback (effective enable folded in) |
| cmd_we_i | input | 1 | Own command word write strobe |
| cmd_wdata_i | input | 4*CODE_W | Own command word write data |
| cmd_rd_o | output | 4*CODE_W | Own command word readback |
| own_sa_i | input | SA_W | Channel slave address |
| own_vra_i | input | RA_W | Channel voltage register address |
| own_cra_i | input | RA_W | Channel command register address |
| dflt_sa_i | input | SA_W | Shared default slave address |
| dflt_vra_i | input | RA_W | Shared default voltage register address |
| dflt_cra_i | input | RA_W | Shared default command register address |
| dflt_cmd_i | input | 4*CODE_W | Shared default command word |
| state_req_i | input | 1 | Power-state request strobe |
| state_i | input | 2 | Requested state: 0 ON, 1 low-power ON, 2 RETENTION, 3 OFF |
| byp_we_i | input | 1 | Bypass word write strobe |
| byp_wdata_i | input | CODE_W+RA_W+SA_W+2 | Bypass word write data |
| byp_rd_o | output | CODE_W+RA_W+SA_W+2 | Bypass word readback |
| frame_start_o | output | 1 | One-cycle frame start strobe |
| frame_sa_o | output | SA_W | Frame slave address |
| frame_ra_o | output | RA_W | Frame register address |
| frame_data_o | output | CODE_W | Frame voltage-select byte |
| bus_done_i | input | 1 | Frame completed by the serial master |
| bus_nack_i | input | 1 | Completion was not acknowledged |
| busy_o | output | 1 | Frame in flight |
| err_o | output | 1 | Sticky not-acknowledge flag |

## Verification
A bypass command and a state request can both become ready in the same cycle, and only one of them may launch. The bench provokes this by writing a valid bypass word on the same clock edge as a state request. It then judges the order from the frame data: the first start strobe must carry the bypass byte, and the second must carry the requested state's code. The second collision is a request that arrives while a frame is in flight. It is provoked with two different requests during one busy period. The check is that exactly one frame follows, with the later code, and no further strobe comes after it.

// File: rtl/vcf_pkg.sv
package vcf_pkg;
  localparam int CFG_W       = 5;
  localparam int NUM_PSTATES = 4;
  localparam int PS_W        = $clog2(NUM_PSTATES);

  typedef enum logic [2:0] {
    FLD_SA    = 3'd0,
    FLD_VRA   = 3'd1,
    FLD_CRA   = 3'd2,
    FLD_CRAEN = 3'd3,
    FLD_CODE  = 3'd4
  } cfg_fld_e;

  typedef enum logic [PS_W-1:0] {
    PS_ON   = 2'd0,
    PS_ONLP = 2'd1,
    PS_RET  = 2'd2,
    PS_OFF  = 2'd3
  } pstate_e;

  // bit position of a config field for either channel variant
  function automatic int cfg_bit(cfg_fld_e f, bit mutant);
    if (!mutant) return int'(f);
    case (f)
      FLD_SA:    return 0;
      FLD_CODE:  return 1;
      FLD_VRA:   return 2;
      FLD_CRA:   return 3;
      default:   return 4;
    endcase
  endfunction
endpackage

// File: rtl/vcf_chan_cfg.sv
module vcf_chan_cfg
  import vcf_pkg::*;
#(
  parameter bit MUTANT_MAP = 1'b0,
  parameter bit DEFAULT_CH = 1'b0,
  parameter int SA_W       = 7,
  parameter int RA_W       = 8,
  parameter int CODE_W     = 8
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          cfg_we_i,
  input  logic [CFG_W-1:0]              cfg_wdata_i,
  output logic [CFG_W-1:0]              cfg_rd_o,
  input  logic                          cmd_we_i,
  input  logic [NUM_PSTATES*CODE_W-1:0] cmd_wdata_i,
  output logic [NUM_PSTATES*CODE_W-1:0] cmd_rd_o,
  input  logic [SA_W-1:0]               own_sa_i,
  input  logic [RA_W-1:0]               own_vra_i,
  input  logic [RA_W-1:0]               own_cra_i,
  input  logic [SA_W-1:0]               dflt_sa_i,
  input  logic [RA_W-1:0]               dflt_vra_i,
  input  logic [RA_W-1:0]               dflt_cra_i,
  input  logic [NUM_PSTATES*CODE_W-1:0] dflt_cmd_i,
  output logic [SA_W-1:0]               sa_eff_o,
  output logic [RA_W-1:0]               ra_eff_o,
  output logic [NUM_PSTATES*CODE_W-1:0] cmd_eff_o
);
  localparam int P_SA    = cfg_bit(FLD_SA, MUTANT_MAP);
  localparam int P_VRA   = cfg_bit(FLD_VRA, MUTANT_MAP);
  localparam int P_CRA   = cfg_bit(FLD_CRA, MUTANT_MAP);
  localparam int P_CRAEN = cfg_bit(FLD_CRAEN, MUTANT_MAP);
  localparam int P_CODE  = cfg_bit(FLD_CODE, MUTANT_MAP);

  logic [CFG_W-1:0]              cfg_q, wmask;
  logic [NUM_PSTATES*CODE_W-1:0] cmd_q;
  logic [RA_W-1:0]               vra_eff, cra_eff;
  logic                          addr_match, craen_eff;

  generate
    if (DEFAULT_CH) begin : g_dflt_ch
      always_comb begin
        wmask = '0;
        wmask[P_CRAEN] = 1'b1;
      end
    end else begin : g_full_ch
      assign wmask = '1;
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '0;
      cmd_q <= '0;
    end else begin
      if (cfg_we_i) cfg_q <= cfg_wdata_i & wmask;
      if (cmd_we_i) cmd_q <= cmd_wdata_i;
    end
  end

  assign vra_eff    = cfg_q[P_VRA] ? own_vra_i : dflt_vra_i;
  assign cra_eff    = cfg_q[P_CRA] ? own_cra_i : dflt_cra_i;
  assign addr_match = (vra_eff == cra_eff);
  assign craen_eff  = cfg_q[P_CRAEN] | addr_match;

  assign sa_eff_o  = cfg_q[P_SA] ? own_sa_i : dflt_sa_i;
  assign ra_eff_o  = craen_eff ? cra_eff : vra_eff;
  assign cmd_eff_o = cfg_q[P_CODE] ? cmd_q : dflt_cmd_i;
  assign cmd_rd_o  = cmd_q;

  always_comb begin
    cfg_rd_o = cfg_q;
    cfg_rd_o[P_CRAEN] = craen_eff;
  end
endmodule

// File: rtl/vcf_state_queue.sv
module vcf_state_queue
  import vcf_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            req_i,
  input  logic [PS_W-1:0] state_i,
  input  logic            take_i,
  output logic            pend_o,
  output logic [PS_W-1:0] state_o
);
  // one slot; a fresh request overrides a take in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_o  <= 1'b0;
      state_o <= '0;
    end else if (req_i) begin
      pend_o  <= 1'b1;
      state_o <= state_i;
    end else if (take_i) begin
      pend_o  <= 1'b0;
    end
  end
endmodule

// File: rtl/vcf_bypass_reg.sv
module vcf_bypass_reg #(
  parameter int SA_W   = 7,
  parameter int RA_W   = 8,
  parameter int CODE_W = 8
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           we_i,
  input  logic [CODE_W+RA_W+SA_W+1:0]    wdata_i,
  input  logic                           done_i,
  output logic [CODE_W+RA_W+SA_W+1:0]    rd_o,
  output logic                           valid_o,
  output logic [SA_W-1:0]                sa_o,
  output logic [RA_W-1:0]                ra_o,
  output logic [CODE_W-1:0]              data_o
);
  localparam int RA_LSB = CODE_W;
  localparam int SA_LSB = CODE_W + RA_W;
  localparam int V_BIT  = CODE_W + RA_W + SA_W + 1;

  logic [V_BIT:0] word_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     word_q        <= '0;
    else if (done_i)                 word_q[V_BIT] <= 1'b0;
    else if (we_i && !word_q[V_BIT]) word_q        <= wdata_i;
  end

  assign rd_o    = word_q;
  assign valid_o = word_q[V_BIT];
  assign data_o  = word_q[CODE_W-1:0];
  assign ra_o    = word_q[RA_LSB +: RA_W];
  assign sa_o    = word_q[SA_LSB +: SA_W];
endmodule

// File: rtl/vcf_launcher.sv
module vcf_launcher
  import vcf_pkg::*;
#(
  parameter int SA_W   = 7,
  parameter int RA_W   = 8,
  parameter int CODE_W = 8
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          byp_pend_i,
  input  logic [SA_W-1:0]               byp_sa_i,
  input  logic [RA_W-1:0]               byp_ra_i,
  input  logic [CODE_W-1:0]             byp_data_i,
  input  logic                          st_pend_i,
  input  logic [PS_W-1:0]               st_i,
  input  logic [SA_W-1:0]               st_sa_i,
  input  logic [RA_W-1:0]               st_ra_i,
  input  logic [NUM_PSTATES*CODE_W-1:0] st_cmd_i,
  input  logic                          done_i,
  input  logic                          nack_i,
  output logic                          take_st_o,
  output logic                          byp_done_o,
  output logic                          start_o,
  output logic [SA_W-1:0]               sa_o,
  output logic [RA_W-1:0]               ra_o,
  output logic [CODE_W-1:0]             data_o,
  output logic                          busy_o,
  output logic                          err_o
);
  logic [CODE_W-1:0] lane [NUM_PSTATES];
  logic              launch_byp, launch_st, finish, is_byp_q;

  // ON occupies the top lane, OFF the bottom one
  generate
    for (genvar s = 0; s < NUM_PSTATES; s++) begin : g_lane
      assign lane[s] = st_cmd_i[(NUM_PSTATES-1-s)*CODE_W +: CODE_W];
    end
  endgenerate

  assign launch_byp = !busy_o && byp_pend_i;
  assign launch_st  = !busy_o && !byp_pend_i && st_pend_i;
  assign finish     = busy_o && done_i;
  assign take_st_o  = launch_st;
  assign byp_done_o = finish && is_byp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o   <= 1'b0;
      start_o  <= 1'b0;
      is_byp_q <= 1'b0;
      err_o    <= 1'b0;
      sa_o     <= '0;
      ra_o     <= '0;
      data_o   <= '0;
    end else begin
      start_o <= launch_byp | launch_st;
      if (launch_byp) begin
        busy_o   <= 1'b1;
        is_byp_q <= 1'b1;
        sa_o     <= byp_sa_i;
        ra_o     <= byp_ra_i;
        data_o   <= byp_data_i;
      end else if (launch_st) begin
        busy_o   <= 1'b1;
        is_byp_q <= 1'b0;
        sa_o     <= st_sa_i;
        ra_o     <= st_ra_i;
        data_o   <= lane[st_i];
      end else if (finish) begin
        busy_o   <= 1'b0;
        is_byp_q <= 1'b0;
      end
      if (finish && nack_i) err_o <= 1'b1;
    end
  end
endmodule

// File: rtl/vcf_frame_gen.sv
module vcf_frame_gen
  import vcf_pkg::*;
#(
  parameter bit MUTANT_MAP = 1'b0,
  parameter bit DEFAULT_CH = 1'b0,
  parameter int SA_W       = 7,
  parameter int RA_W       = 8,
  parameter int CODE_W     = 8
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          cfg_we_i,
  input  logic [4:0]                    cfg_wdata_i,
  output logic [4:0]                    cfg_rd_o,
  input  logic                          cmd_we_i,
  input  logic [4*CODE_W-1:0]           cmd_wdata_i,
  output logic [4*CODE_W-1:0]           cmd_rd_o,
  input  logic [SA_W-1:0]               own_sa_i,
  input  logic [RA_W-1:0]               own_vra_i,
  input  logic [RA_W-1:0]               own_cra_i,
  input  logic [SA_W-1:0]               dflt_sa_i,
  input  logic [RA_W-1:0]               dflt_vra_i,
  input  logic [RA_W-1:0]               dflt_cra_i,
  input  logic [4*CODE_W-1:0]           dflt_cmd_i,
  input  logic                          state_req_i,
  input  logic [1:0]                    state_i,
  input  logic                          byp_we_i,
  input  logic [CODE_W+RA_W+SA_W+1:0]   byp_wdata_i,
  output logic [CODE_W+RA_W+SA_W+1:0]   byp_rd_o,
  output logic                          frame_start_o,
  output logic [SA_W-1:0]               frame_sa_o,
  output logic [RA_W-1:0]               frame_ra_o,
  output logic [CODE_W-1:0]             frame_data_o,
  input  logic                          bus_done_i,
  input  logic                          bus_nack_i,
  output logic                          busy_o,
  output logic                          err_o
);
  logic [SA_W-1:0]     st_sa, byp_sa;
  logic [RA_W-1:0]     st_ra, byp_ra;
  logic [CODE_W-1:0]   byp_data;
  logic [4*CODE_W-1:0] st_cmd;
  logic                byp_pend, byp_done, st_pend, take_st;
  logic [PS_W-1:0]     st_q;

  vcf_chan_cfg #(
    .MUTANT_MAP(MUTANT_MAP), .DEFAULT_CH(DEFAULT_CH),
    .SA_W(SA_W), .RA_W(RA_W), .CODE_W(CODE_W)
  ) u_cfg (
    .clk_i, .rst_ni,
    .cfg_we_i, .cfg_wdata_i, .cfg_rd_o,
    .cmd_we_i, .cmd_wdata_i, .cmd_rd_o,
    .own_sa_i, .own_vra_i, .own_cra_i,
    .dflt_sa_i, .dflt_vra_i, .dflt_cra_i, .dflt_cmd_i,
    .sa_eff_o(st_sa), .ra_eff_o(st_ra), .cmd_eff_o(st_cmd)
  );

  vcf_state_queue u_q (
    .clk_i, .rst_ni,
    .req_i(state_req_i), .state_i(state_i), .take_i(take_st),
    .pend_o(st_pend), .state_o(st_q)
  );

  vcf_bypass_reg #(.SA_W(SA_W), .RA_W(RA_W), .CODE_W(CODE_W)) u_byp (
    .clk_i, .rst_ni,
    .we_i(byp_we_i), .wdata_i(byp_wdata_i), .done_i(byp_done),
    .rd_o(byp_rd_o), .valid_o(byp_pend),
    .sa_o(byp_sa), .ra_o(byp_ra), .data_o(byp_data)
  );

  vcf_launcher #(.SA_W(SA_W), .RA_W(RA_W), .CODE_W(CODE_W)) u_launch (
    .clk_i, .rst_ni,
    .byp_pend_i(byp_pend), .byp_sa_i(byp_sa), .byp_ra_i(byp_ra), .byp_data_i(byp_data),
    .st_pend_i(st_pend), .st_i(st_q), .st_sa_i(st_sa), .st_ra_i(st_ra), .st_cmd_i(st_cmd),
    .done_i(bus_done_i), .nack_i(bus_nack_i),
    .take_st_o(take_st), .byp_done_o(byp_done),
    .start_o(frame_start_o), .sa_o(frame_sa_o), .ra_o(frame_ra_o), .data_o(frame_data_o),
    .busy_o(busy_o), .err_o(err_o)
  );
endmodule

// File: rtl/vcf_frame_gen_chk.sv
module vcf_frame_gen_chk #(
  parameter int SA_W   = 7,
  parameter int RA_W   = 8,
  parameter int CODE_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              frame_start_o,
  input logic              busy_o,
  input logic              err_o,
  input logic [SA_W-1:0]   frame_sa_o,
  input logic [RA_W-1:0]   frame_ra_o,
  input logic [CODE_W-1:0] frame_data_o,
  input logic              bus_done_i,
  input logic              bus_nack_i,
  input logic              byp_valid
);
  p_start_single_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_start_o |=> !frame_start_o);
  p_start_busy_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_start_o |-> busy_o);
  p_start_from_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_start_o |-> !$past(busy_o));
  p_fields_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !frame_start_o) |-> $stable({frame_sa_o, frame_ra_o, frame_data_o}));
  p_done_idles_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && bus_done_i) |=> !busy_o);
  p_valid_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(byp_valid) |-> $past(busy_o && bus_done_i));
  p_nack_err_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && bus_done_i && bus_nack_i) |=> err_o);
  p_err_sticky_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o);
endmodule

bind vcf_frame_gen vcf_frame_gen_chk #(.SA_W(SA_W), .RA_W(RA_W), .CODE_W(CODE_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .frame_start_o(frame_start_o), .busy_o(busy_o),
  .err_o(err_o), .frame_sa_o(frame_sa_o), .frame_ra_o(frame_ra_o),
  .frame_data_o(frame_data_o), .bus_done_i(bus_done_i), .bus_nack_i(bus_nack_i),
  .byp_valid(byp_rd_o[CODE_W+RA_W+SA_W+1])
);

// File: tb/sim_vcf_frame_gen.sv
`timescale 1ns/1ps
module sim_vcf_frame_gen;
  logic clk = 1'b0, rst_ni = 1'b0;
  always #2.5 clk = ~clk;

  logic        cfg_we = 0, cmd_we = 0, state_req = 0, byp_we = 0, done = 0, nack = 0;
  logic [4:0]  cfg_wd = 0;
  logic [31:0] cmd_wd = 0, dflt_cmd = 32'hA1B2C3D4;
  logic [6:0]  own_sa = 7'h12, dflt_sa = 7'h48;
  logic [7:0]  own_vra = 8'h30, own_cra = 8'h31, dflt_vra = 8'h10, dflt_cra = 8'h20;
  logic [1:0]  st = 0;
  logic [24:0] byp_wd = 0;

  logic [4:0]  cfg_rd [3];
  logic [31:0] cmd_rd [3];
  logic [24:0] byp_rd [3];
  logic        start [3], busy [3], err [3];
  logic [6:0]  fsa [3];
  logic [7:0]  fra [3], fdata [3];

  vcf_frame_gen u0 (.clk_i(clk), .rst_ni, .cfg_we_i(cfg_we), .cfg_wdata_i(cfg_wd), .cfg_rd_o(cfg_rd[0]),
    .cmd_we_i(cmd_we), .cmd_wdata_i(cmd_wd), .cmd_rd_o(cmd_rd[0]), .own_sa_i(own_sa), .own_vra_i(own_vra),
    .own_cra_i(own_cra), .dflt_sa_i(dflt_sa), .dflt_vra_i(dflt_vra), .dflt_cra_i(dflt_cra), .dflt_cmd_i(dflt_cmd),
    .state_req_i(state_req), .state_i(st), .byp_we_i(byp_we), .byp_wdata_i(byp_wd), .byp_rd_o(byp_rd[0]),
    .frame_start_o(start[0]), .frame_sa_o(fsa[0]), .frame_ra_o(fra[0]), .frame_data_o(fdata[0]),
    .bus_done_i(done), .bus_nack_i(nack), .busy_o(busy[0]), .err_o(err[0]));
  vcf_frame_gen #(.MUTANT_MAP(1'b1)) u1 (.clk_i(clk), .rst_ni, .cfg_we_i(cfg_we), .cfg_wdata_i(cfg_wd), .cfg_rd_o(cfg_rd[1]),
    .cmd_we_i(cmd_we), .cmd_wdata_i(cmd_wd), .cmd_rd_o(cmd_rd[1]), .own_sa_i(own_sa), .own_vra_i(own_vra),
    .own_cra_i(own_cra), .dflt_sa_i(dflt_sa), .dflt_vra_i(dflt_vra), .dflt_cra_i(dflt_cra), .dflt_cmd_i(dflt_cmd),
    .state_req_i(state_req), .state_i(st), .byp_we_i(byp_we), .byp_wdata_i(byp_wd), .byp_rd_o(byp_rd[1]),
    .frame_start_o(start[1]), .frame_sa_o(fsa[1]), .frame_ra_o(fra[1]), .frame_data_o(fdata[1]),
    .bus_done_i(done), .bus_nack_i(nack), .busy_o(busy[1]), .err_o(err[1]));
  vcf_frame_gen #(.DEFAULT_CH(1'b1)) u2 (.clk_i(clk), .rst_ni, .cfg_we_i(cfg_we), .cfg_wdata_i(cfg_wd), .cfg_rd_o(cfg_rd[2]),
    .cmd_we_i(cmd_we), .cmd_wdata_i(cmd_wd), .cmd_rd_o(cmd_rd[2]), .own_sa_i(own_sa), .own_vra_i(own_vra),
    .own_cra_i(own_cra), .dflt_sa_i(dflt_sa), .dflt_vra_i(dflt_vra), .dflt_cra_i(dflt_cra), .dflt_cmd_i(dflt_cmd),
    .state_req_i(state_req), .state_i(st), .byp_we_i(byp_we), .byp_wdata_i(byp_wd), .byp_rd_o(byp_rd[2]),
    .frame_start_o(start[2]), .frame_sa_o(fsa[2]), .frame_ra_o(fra[2]), .frame_data_o(fdata[2]),
    .bus_done_i(done), .bus_nack_i(nack), .busy_o(busy[2]), .err_o(err[2]));

  int n_chk = 0, n_fail = 0;
  logic [31:0] own_cmd_m = 0;
  logic [4:0]  cfg_m = 0;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // field index: 0 sa, 1 vra, 2 cra, 3 craen, 4 code
  function automatic int pos(int f, bit mut);
    if (!mut) return f;
    case (f) 0: return 0; 1: return 2; 2: return 3; 3: return 4; default: return 1; endcase
  endfunction
  function automatic logic [4:0] stored(logic [4:0] w, bit mut, bit defch);
    return defch ? (w & (5'b1 << pos(3, mut))) : w;
  endfunction
  function automatic logic [7:0] m_vra(logic [4:0] s, bit mut); return s[pos(1, mut)] ? own_vra : dflt_vra; endfunction
  function automatic logic [7:0] m_cra(logic [4:0] s, bit mut); return s[pos(2, mut)] ? own_cra : dflt_cra; endfunction
  function automatic logic [7:0] m_ra(logic [4:0] s, bit mut);
    return (s[pos(3, mut)] || m_vra(s, mut) == m_cra(s, mut)) ? m_cra(s, mut) : m_vra(s, mut);
  endfunction
  function automatic logic [4:0] m_rd(logic [4:0] s, bit mut);
    logic [4:0] r = s;
    if (m_vra(s, mut) == m_cra(s, mut)) r[pos(3, mut)] = 1'b1;
    return r;
  endfunction
  function automatic logic [6:0] m_sa(logic [4:0] s, bit mut); return s[pos(0, mut)] ? own_sa : dflt_sa; endfunction
  function automatic logic [7:0] m_data(logic [4:0] s, bit mut, logic [1:0] ps);
    logic [31:0] w = s[pos(4, mut)] ? own_cmd_m : dflt_cmd;
    return w[(3 - ps) * 8 +: 8];
  endfunction

  task automatic tick(); @(negedge clk); endtask
  task automatic wait_start(string tag);
    for (int i = 0; i < 20; i++) begin
      if (start[0]) return;
      tick();
    end
    chk({tag, " start seen"}, 0, 1);
  endtask
  task automatic finish_frame(logic nk);
    done = 1; nack = nk; tick(); done = 0; nack = 0; tick();
  endtask
  task automatic req_state(logic [1:0] s);
    state_req = 1; st = s; tick(); state_req = 0;
  endtask
  task automatic count_starts(int cycles, output int n);
    n = 0;
    for (int i = 0; i < cycles; i++) begin if (start[0]) n++; tick(); end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    int n;
    void'($urandom(32'd4711));
    repeat (3) tick();
    rst_ni = 1; tick();
    // R1 reset state
    chk("R1 start", start[0], 0); chk("R1 busy", busy[0], 0); chk("R1 err", err[0], 0);
    chk("R1 cfg", cfg_rd[0], 0); chk("R1 cmd", cmd_rd[0], 0); chk("R1 valid", byp_rd[0][24], 0);

    // R7/R8 bypass frame
    byp_wd = {1'b1, 1'b0, 7'h5A, 8'h77, 8'hC3}; byp_we = 1; tick(); byp_we = 0;
    wait_start("R7");
    chk("R7 sa", fsa[0], 7'h5A); chk("R7 ra", fra[0], 8'h77); chk("R7 data", fdata[0], 8'hC3);
    tick();
    chk("R9 start one cycle", start[0], 0); chk("R9 busy held", busy[0], 1);
    chk("R8 valid held", byp_rd[0][24], 1);
    byp_wd = {1'b1, 1'b0, 7'h01, 8'h02, 8'h03}; byp_we = 1; tick(); byp_we = 0;
    chk("R7 write ignored", byp_rd[0], {1'b1, 1'b0, 7'h5A, 8'h77, 8'hC3});
    chk("R9 fields stable", {fsa[0], fra[0], fdata[0]}, {7'h5A, 8'h77, 8'hC3});
    done = 1; tick(); done = 0;
    chk("R8 valid cleared", byp_rd[0][24], 0); chk("R9 idle after done", busy[0], 0);
    tick();

    // R10 bypass and state request together
    byp_wd = {1'b1, 1'b0, 7'h33, 8'h44, 8'h9E}; byp_we = 1; state_req = 1; st = 2'd2;
    tick(); byp_we = 0; state_req = 0;
    wait_start("R10");
    chk("R10 bypass first", fdata[0], 8'h9E);
    finish_frame(0);
    wait_start("R10b");
    chk("R10 state second", fdata[0], m_data(cfg_m, 0, 2'd2));
    chk("R2 default word RET lane", fdata[0], 8'hC3);
    finish_frame(0);

    // R11 one-deep latest-wins queue
    req_state(2'd0); wait_start("R11");
    chk("R2 ON lane", fdata[0], 8'hA1);
    tick(); req_state(2'd1); req_state(2'd3);
    finish_frame(0);
    wait_start("R11b");
    chk("R11 latest state", fdata[0], 8'hD4);
    finish_frame(0);
    count_starts(10, n);
    chk("R11 single follow-up", n, 0);

    // random configs and states, plus R4/R5 variants
    for (int it = 0; it < 60; it++) begin
      logic [1:0] ps;
      cfg_wd = 5'($urandom); cfg_m = cfg_wd;
      own_sa = 7'($urandom); dflt_sa = 7'($urandom);
      own_vra = 8'($urandom); dflt_vra = 8'($urandom);
      own_cra = ($urandom % 4 == 0) ? own_vra : 8'($urandom);
      dflt_cra = ($urandom % 4 == 0) ? dflt_vra : 8'($urandom);
      dflt_cmd = $urandom; cmd_wd = $urandom; own_cmd_m = cmd_wd;
      cfg_we = 1; cmd_we = 1; tick(); cfg_we = 0; cmd_we = 0;
      chk("R6 cfg readback u0", cfg_rd[0], m_rd(stored(cfg_m, 0, 0), 0));
      chk("R4 cfg readback u1", cfg_rd[1], m_rd(stored(cfg_m, 1, 0), 1));
      chk("R5 cfg readback u2", cfg_rd[2], m_rd(stored(cfg_m, 0, 1), 0));
      chk("R2 own word", cmd_rd[0], own_cmd_m);
      ps = 2'($urandom); req_state(ps);
      wait_start("R3");
      chk("R3 sa", fsa[0], m_sa(cfg_m, 0));
      chk("R6 ra", fra[0], m_ra(cfg_m, 0));
      chk("R2 data", fdata[0], m_data(cfg_m, 0, ps));
      chk("R4 mutant sa", fsa[1], m_sa(cfg_m, 1));
      chk("R4 mutant ra", fra[1], m_ra(cfg_m, 1));
      chk("R4 mutant data", fdata[1], m_data(cfg_m, 1, ps));
      chk("R5 default-ch sa", fsa[2], m_sa(stored(cfg_m, 0, 1), 0));
      chk("R5 default-ch ra", fra[2], m_ra(stored(cfg_m, 0, 1), 0));
      chk("R5 default-ch data", fdata[2], m_data(stored(cfg_m, 0, 1), 0, ps));
      finish_frame(0);
    end

    // R12 nack: sticky error, no retry
    chk("R12 err clear before", err[0], 0);
    req_state(2'd1); wait_start("R12");
    finish_frame(1);
    chk("R12 err set", err[0], 1);
    count_starts(10, n);
    chk("R12 no retry", n, 0);
    req_state(2'd3); wait_start("R12b");
    finish_frame(0);
    chk("R12 err sticky", err[0], 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule